// File: doc/BRIEF.md
# Pipeline Hazard Controller (Forwarding, Interlock and Branch Squash)

This block holds the hazard control for a five-stage, 16-bit load/store pipeline with eight general registers. The stages are fetch, decode with register read, execute with address calculation, memory access and write-back. The block compares the source register numbers of the instructions in decode and execute with the destination register numbers of the instructions further down the pipe. From these comparisons it drives the operand-select lines of the execute stage, the register-file bypass in decode, a front-end stall, and the kill controls that turn stage registers into bubbles.

The block provides exactly two forwarding paths. The first takes the write-back value into a register read in decode during the same cycle. The second takes an ALU result at the start of the memory stage into the start of execute. Any dependence that these two paths cannot serve holds the instruction in decode until the write-back bypass can supply the value. Branches are predicted not-taken. When a branch resolves taken in execute, the two younger instructions are squashed. The datapath turns each killed stage into a bubble, with its write-enables and memory strobes cleared.

Every output is a combinational function of the current stage contents. The clock and reset only time the embedded assertions.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: `fwd_a` (or `fwd_b`) is 1 in the same cycle when the memory-stage instruction is valid, writes a register, is not a load, and its destination equals `ex_src_a` (or `ex_src_b`). A value of 1 selects the forwarded ALU result and 0 selects the register value. Register numbers 0 and 7 are treated like any other number.
- R2: `fwd_a` and `fwd_b` stay 0 when the memory-stage instruction is invalid, has its write-enable low, or is a load.
- R3: `byp_a` (or `byp_b`) is 1 when the write-back instruction is valid, writes a register, and its destination equals `id_src_a` (or `id_src_b`). Loads are included.
- R4: Load-use interlock. A valid writing load in execute whose destination equals a used source of a valid decode instruction gives `stall_front`=1, `kill_idex`=1 and `kill_ifid`=0. A non-load producer in the same position causes no stall.
- R5: Distance-two interlock. A valid writing memory-stage instruction of any kind whose destination equals a used source of a valid decode instruction gives `stall_front`=1 and `kill_idex`=1.
- R6: A source whose use flag (`id_use_a`/`id_use_b`) is 0, or a decode stage with `id_valid`=0, never causes a stall.
- R7: A taken branch (`br_resolved`=1 and `br_taken`=1) gives `kill_ifid`=1, `kill_idex`=1 and `stall_front`=0. The squash wins over any interlock in the same cycle.
- R8: A resolved branch that is not taken, or `br_taken` without `br_resolved`, squashes nothing. The interlock outputs then follow R4 to R6.
- R9: All outputs follow their inputs in the same cycle, with no register in any path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (assertion timing only) |
| rst_n | input | 1 | Active-low reset (disables assertions) |
| id_src_a | input | 3 | Decode source register A |
| id_src_b | input | 3 | Decode source register B |
| id_use_a | input | 1 | Decode instruction reads source A |
| id_use_b | input | 1 | Decode instruction reads source B |
| id_valid | input | 1 | Decode stage holds a live instruction |
| ex_src_a | input | 3 | Execute source register A |
| ex_src_b | input | 3 | Execute source register B |
| ex_dst | input | 3 | Execute destination register |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 3 | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_valid | input | 1 | Memory stage holds a live instruction |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 3 | Write-back destination register |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_valid | input | 1 | Write-back stage holds a live instruction |
| br_resolved | input | 1 | A branch in execute resolves this cycle |
| br_taken | input | 1 | The resolving branch is taken |
| fwd_a | output | 1 | Execute operand A takes the forwarded ALU result |
| fwd_b | output | 1 | Execute operand B takes the forwarded ALU result |
| byp_a | output | 1 | Decode read A takes the write-back value |
| byp_b | output | 1 | Decode read B takes the write-back value |
| stall_front | output | 1 | Hold the PC and the fetch/decode register |
| kill_idex | output | 1 | Load a bubble into the decode/execute register |
| kill_ifid | output | 1 | Load a bubble into the fetch/decode register |

## Verification
On every cycle the assertions check several properties. A squash always beats an interlock. A stall always comes with a bubble and never with a fetch kill. An unresolved branch kills nothing. An idle decode stage never stalls. No forward or bypass is selected without a valid writing producer, and a load in the memory stage is never forwarded. Only the bench scenarios can show that each select is raised for the right match. These include the R0 and R7 cases, the unused-source cases, and the load case against the ALU case. A pseudo-random sweep then compares every output with a model written from the requirements.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  parameter int unsigned NUM_REGS = 8;
  localparam int unsigned REG_W = $clog2(NUM_REGS);

  typedef logic [REG_W-1:0] regidx_t;

  typedef struct packed {
    logic    valid;
    logic    wen;
    regidx_t dst;
  } producer_t;

  // True when a live, writing producer targets register src.
  function automatic logic feeds(producer_t p, regidx_t src);
    return p.valid && p.wen && (p.dst == src);
  endfunction

  // True when a used source of the consumer depends on the producer.
  function automatic logic depends(producer_t p, regidx_t src, logic used);
    return used && feeds(p, src);
  endfunction
endpackage

// File: rtl/hzc_ex_fwd.sv
module hzc_ex_fwd
  import hzc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  producer_t                        mem_p,
  input  logic                             mem_is_load,
  input  logic [NUM_SRC-1:0][REG_W-1:0]    ex_src,
  output logic [NUM_SRC-1:0]               fwd
);
  // Only ALU results exist at the start of the memory stage.
  logic alu_ready;
  assign alu_ready = !mem_is_load;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign fwd[i] = alu_ready && feeds(mem_p, ex_src[i]);
  end

  a_r2_no_load_forward: assert property (@(posedge clk) disable iff (!rst_n)
    mem_is_load |-> (fwd == '0));
  a_r1_forward_has_producer: assert property (@(posedge clk) disable iff (!rst_n)
    (|fwd) |-> (mem_p.valid && mem_p.wen));
endmodule

// File: rtl/hzc_id_bypass.sv
module hzc_id_bypass
  import hzc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  producer_t                        wb_p,
  input  logic [NUM_SRC-1:0][REG_W-1:0]    id_src,
  output logic [NUM_SRC-1:0]               byp
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign byp[i] = feeds(wb_p, id_src[i]);
  end

  a_r3_bypass_has_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (|byp) |-> (wb_p.valid && wb_p.wen));
endmodule

// File: rtl/hzc_interlock.sv
module hzc_interlock
  import hzc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0][REG_W-1:0]    id_src,
  input  logic [NUM_SRC-1:0]               id_use,
  input  logic                             id_valid,
  input  producer_t                        ex_p,
  input  logic                             ex_is_load,
  input  producer_t                        mem_p,
  input  logic                             br_resolved,
  input  logic                             br_taken,
  output logic                             stall_front,
  output logic                             kill_idex,
  output logic                             kill_ifid
);
  logic [NUM_SRC-1:0] load_dep;
  logic [NUM_SRC-1:0] mem_dep;
  logic load_use_hit;
  logic mem_dist_hit;
  logic hazard;
  logic squash;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign load_dep[i] = depends(ex_p, id_src[i], id_use[i]);
    assign mem_dep[i]  = depends(mem_p, id_src[i], id_use[i]);
  end

  assign load_use_hit = id_valid && ex_is_load && (|load_dep);
  // The value from memory stage reaches decode only through write-back.
  assign mem_dist_hit = id_valid && (|mem_dep);
  assign hazard       = load_use_hit || mem_dist_hit;
  assign squash       = br_resolved && br_taken;

  assign stall_front = hazard && !squash;
  assign kill_idex   = hazard || squash;
  assign kill_ifid   = squash;

  a_r7_squash_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (br_resolved && br_taken) |-> (kill_ifid && kill_idex && !stall_front));
  a_r4_stall_makes_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    stall_front |-> (kill_idex && !kill_ifid));
  a_r8_unresolved_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
    !br_resolved |-> !kill_ifid);
  a_r6_idle_decode_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !stall_front);
  a_r5_stall_has_producer: assert property (@(posedge clk) disable iff (!rst_n)
    stall_front |-> ((ex_p.valid && ex_p.wen) || (mem_p.valid && mem_p.wen)));
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hzc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_use_a,
  input  logic             id_use_b,
  input  logic             id_valid,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_valid,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_valid,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  input  logic             wb_valid,
  input  logic             br_resolved,
  input  logic             br_taken,
  output logic             fwd_a,
  output logic             fwd_b,
  output logic             byp_a,
  output logic             byp_b,
  output logic             stall_front,
  output logic             kill_idex,
  output logic             kill_ifid
);
  localparam int unsigned NUM_SRC = 2;

  producer_t ex_p, mem_p, wb_p;
  logic [NUM_SRC-1:0][REG_W-1:0] id_src, ex_src;
  logic [NUM_SRC-1:0] id_use, fwd, byp;

  assign ex_p   = '{valid: ex_valid,  wen: ex_wen,  dst: ex_dst};
  assign mem_p  = '{valid: mem_valid, wen: mem_wen, dst: mem_dst};
  assign wb_p   = '{valid: wb_valid,  wen: wb_wen,  dst: wb_dst};
  assign id_src = {id_src_b, id_src_a};
  assign ex_src = {ex_src_b, ex_src_a};
  assign id_use = {id_use_b, id_use_a};

  hzc_ex_fwd #(.NUM_SRC(NUM_SRC)) u_fwd (
    .clk(clk), .rst_n(rst_n), .mem_p(mem_p), .mem_is_load(mem_load),
    .ex_src(ex_src), .fwd(fwd)
  );

  hzc_id_bypass #(.NUM_SRC(NUM_SRC)) u_byp (
    .clk(clk), .rst_n(rst_n), .wb_p(wb_p), .id_src(id_src), .byp(byp)
  );

  hzc_interlock #(.NUM_SRC(NUM_SRC)) u_ilk (
    .clk(clk), .rst_n(rst_n), .id_src(id_src), .id_use(id_use),
    .id_valid(id_valid), .ex_p(ex_p), .ex_is_load(ex_load), .mem_p(mem_p),
    .br_resolved(br_resolved), .br_taken(br_taken),
    .stall_front(stall_front), .kill_idex(kill_idex), .kill_ifid(kill_ifid)
  );

  assign fwd_a = fwd[0];
  assign fwd_b = fwd[1];
  assign byp_a = byp[0];
  assign byp_b = byp[1];

  // R1/R4: a load in execute stalls; while decode waits, nothing is forwarded from it.
  a_r4_load_use_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_wen && ex_load && id_valid && id_use_a && (id_src_a == ex_dst)
     && !(br_resolved && br_taken)) |-> stall_front);
endmodule

// File: tb/pipe_hazard_ctl_test.sv
module pipe_hazard_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
  logic id_use_a, id_use_b, id_valid, ex_wen, ex_valid, ex_load;
  logic mem_wen, mem_valid, mem_load, wb_wen, wb_valid, br_resolved, br_taken;
  logic fwd_a, fwd_b, byp_a, byp_b, stall_front, kill_idex, kill_ifid;

  pipe_hazard_ctl uut (.*);

  typedef struct packed {
    logic [2:0] ia, ib; logic iua, iub, iv;
    logic [2:0] xa, xb, xrd; logic xwe, xv, xld;
    logic [2:0] mrd; logic mwe, mv, mld;
    logic [2:0] wrd; logic wwe, wv;
    logic brr, brt;
    logic [6:0] exp;  // {fwd_a,fwd_b,byp_a,byp_b,stall,kill_idex,kill_ifid}
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,0,0, 0,3,0,0,0,0, 0,1,1,0, 0,0,0, 0,0, 7'b1000000},
    '{0,0,0,0,0, 2,7,0,0,0,0, 7,1,1,0, 0,0,0, 0,0, 7'b0100000},
    '{0,0,0,0,0, 5,5,0,0,0,0, 5,1,1,1, 0,0,0, 0,0, 7'b0000000},
    '{0,0,0,0,0, 4,1,0,0,0,0, 4,0,1,0, 0,0,0, 0,0, 7'b0000000},
    '{2,2,1,1,1, 0,0,0,0,0,0, 0,0,0,0, 2,1,1, 0,0, 7'b0011000},
    '{1,0,1,0,1, 0,0,1,1,1,1, 0,0,0,0, 0,0,0, 0,0, 7'b0000110},
    '{1,0,1,0,1, 0,0,1,1,1,0, 0,0,0,0, 0,0,0, 0,0, 7'b0000000},
    '{0,6,0,1,1, 0,0,0,0,0,0, 6,1,1,0, 0,0,0, 0,0, 7'b0000110},
    '{1,0,0,0,1, 0,0,1,1,1,1, 0,0,0,0, 0,0,0, 0,0, 7'b0000000},
    '{1,0,1,0,1, 0,0,1,1,1,1, 0,0,0,0, 0,0,0, 1,1, 7'b0000011},
    '{1,0,1,0,1, 0,0,1,1,1,1, 0,0,0,0, 0,0,0, 1,0, 7'b0000110},
    '{1,0,1,0,1, 0,0,1,1,1,1, 0,0,0,0, 0,0,0, 0,1, 7'b0000110},
    '{0,0,0,0,0, 3,3,0,0,0,0, 3,1,1,0, 0,0,0, 0,0, 7'b1100000}
  };
  localparam string TAG [NV] = '{"R1","R1","R2","R2","R3","R4","R4",
                                 "R5","R6","R7","R8","R8","R1"};

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic drive(vec_t v);
    id_src_a = v.ia; id_src_b = v.ib; id_use_a = v.iua; id_use_b = v.iub;
    id_valid = v.iv; ex_src_a = v.xa; ex_src_b = v.xb; ex_dst = v.xrd;
    ex_wen = v.xwe; ex_valid = v.xv; ex_load = v.xld;
    mem_dst = v.mrd; mem_wen = v.mwe; mem_valid = v.mv; mem_load = v.mld;
    wb_dst = v.wrd; wb_wen = v.wwe; wb_valid = v.wv;
    br_resolved = v.brr; br_taken = v.brt;
  endtask

  task automatic check(string tag, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {fwd_a, fwd_b, byp_a, byp_b, stall_front, kill_idex, kill_ifid};
  endfunction

  // Model written from the requirements.
  function automatic logic [6:0] model(vec_t v);
    logic fa, fb, ba, bb, lu, md, sq;
    fa = v.mv & v.mwe & ~v.mld & (v.mrd == v.xa);
    fb = v.mv & v.mwe & ~v.mld & (v.mrd == v.xb);
    ba = v.wv & v.wwe & (v.wrd == v.ia);
    bb = v.wv & v.wwe & (v.wrd == v.ib);
    lu = v.xv & v.xwe & v.xld & v.iv &
         ((v.iua & (v.ia == v.xrd)) | (v.iub & (v.ib == v.xrd)));
    md = v.mv & v.mwe & v.iv &
         ((v.iua & (v.ia == v.mrd)) | (v.iub & (v.ib == v.mrd)));
    sq = v.brr & v.brt;
    return {fa, fb, ba, bb, (lu | md) & ~sq, lu | md | sq, sq};
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    logic [31:0] s;
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("reset", outs(), 7'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #2;
      check(TAG[i], outs(), VEC[i].exp);
    end

    // R6: hazard present but decode empty
    @(negedge clk);
    v = VEC[5]; v.iv = 1'b0; drive(v); #2;
    check("R6", outs(), 7'b0);

    // R9: pseudo-random sweep, same-cycle response against the model
    s = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      v = vec_t'({s[31:0], s[27:0]} ^ {s[15:0], s[31:0], s[11:0]});
      v.exp = '0;
      @(negedge clk);
      drive(v);
      #1;
      check("R9", outs(), model(v));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule